// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time as packed BCD fields: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A free-running prescaler divides the incoming 32768 Hz clock down to a once-per-second advance. The advance ripples each field into the next, carrying through days, months and years. The length of February comes from a leap flag that software writes. The counter computes no leap years itself.

Software sets the time through a simple register port. Writes to the seven time fields only fill a staging copy. The live counter takes the whole staged set in one step, and only when the trigger word is written with bit 15 set.

A two-state machine sequences this load:
- In `ST_RUN` (counting) the live time advances on each prescaler tick, provided 24-hour mode is enabled.
- A trigger write moves the machine to `ST_LOAD` (load pending). The trigger bit reads back as 1 in this state.
- On the next edge the staged set is copied into the live time and the prescaler is cleared. The machine then returns to `ST_RUN`, unless another trigger write arrives in that same cycle, in which case it stays in `ST_LOAD`.

Read offsets return the live time, the pending bit and the control bit.

Top module: `calclk_bcd`

## Requirements
- R1: After reset, the live time reads as follows: seconds, minutes, hours and weekday 0; day 01; month 01; year 00; leap flag 0. The control bit reads 0 and the pending bit reads 0.
- R2: The offset map is 0 seconds, 1 minutes, 2 hours, 3 weekday (0 to 6), 4 day of month, 5 month (01 to 12), 6 year, 7 trigger and 8 control. The year offset holds the BCD year in bits 7:0 and the leap flag in bit 15. The trigger offset uses bit 15. The control offset uses bit 0 as the 24-hour enable. Each field reads back right-aligned, with the upper bits 0. Unmapped offsets read 0.
- R3: Writes to offsets 0 to 6 do not change the live time until a trigger write with bit 15 set. A trigger write with bit 15 clear has no effect.
- R4: After a trigger write with bit 15 set, bit 15 of offset 7 reads 1 for one cycle. On the following edge all seven fields and the leap flag load together, and the bit reads 0 again.
- R5: A load clears the prescaler. The first advance comes 2^PRESCALE_W cycles after the load edge, and later advances follow every 2^PRESCALE_W cycles.
- R6: The time advances only while control bit 0 is 1. While it is 0, the live time holds.
- R7: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into the day.
- R8: On a day carry, the weekday steps by 1, and 6 wraps to 0.
- R9: The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends at 29 when the leap flag is 1 and at 28 when it is 0. The last day wraps to 01 and steps the month.
- R10: Month 12 wraps to 01 and steps the year. Year 99 wraps to 00. The counter never changes the leap flag.
- R11: Every field counts in BCD. A low digit of 9 becomes 0 and carries into the tens digit (09 to 10, 19 to 20).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write offset |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read offset |
| rd_data | output | 16 | Read data for rd_addr (combinational) |

## Verification
The hardest cases to reach from the ports are the month-end and year-end carries. At one advance per second, those are days of ticks away. The bench therefore shrinks the prescaler and loads a time one second before each boundary: one load at the day before the last day, and one at 23:59:59 on the last day. This covers every month with the leap flag both clear and set, and ends with 31 December of year 99. A separate run of 130 consecutive ticks from 00:58:00 is compared, tick by tick, against hours, minutes and seconds computed arithmetically from the elapsed count.

// File: rtl/calclk_pkg.sv
package calclk_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_SEC  = 4'd0;
    localparam logic [ADDR_W-1:0] A_MIN  = 4'd1;
    localparam logic [ADDR_W-1:0] A_HOUR = 4'd2;
    localparam logic [ADDR_W-1:0] A_WDAY = 4'd3;
    localparam logic [ADDR_W-1:0] A_MDAY = 4'd4;
    localparam logic [ADDR_W-1:0] A_MON  = 4'd5;
    localparam logic [ADDR_W-1:0] A_YEAR = 4'd6;
    localparam logic [ADDR_W-1:0] A_TRIG = 4'd7;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'd8;

    typedef struct packed {
        logic       leap;
        logic [7:0] year;
        logic [4:0] mon;
        logic [5:0] mday;
        logic [2:0] wday;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } cal_time_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_LOAD = 1'b1
    } ld_state_t;

    localparam cal_time_t CAL_RESET = '{leap: 1'b0, year: 8'h00, mon: 5'h01,
                                        mday: 6'h01, wday: 3'd0, hour: 6'h00,
                                        min: 7'h00, sec: 7'h00};

    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_inc7(input logic [6:0] v);
        return (v[3:0] == 4'd9) ? {v[6:4] + 3'd1, 4'd0} : {v[6:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [5:0] bcd_inc6(input logic [5:0] v);
        return (v[3:0] == 4'd9) ? {v[5:4] + 2'd1, 4'd0} : {v[5:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [4:0] bcd_inc5(input logic [4:0] v);
        return (v[3:0] == 4'd9) ? {v[4] + 1'b1, 4'd0} : {v[4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [5:0] month_end(input logic [4:0] mon, input logic leap);
        case (mon)
            5'h02:                      return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/calclk_prescaler.sv
module calclk_prescaler #(
    parameter int W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam logic [W-1:0] ONE = 1;
    localparam logic [W-1:0] MAX = '1;

    logic [W-1:0] cnt_q;

    assign tick = (cnt_q == MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + ONE;
    end

    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R5
    clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tick);

endmodule

// File: rtl/calclk_advance.sv
module calclk_advance
    import calclk_pkg::*;
(
    input  cal_time_t cur,
    output cal_time_t nxt
);
    logic       sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;
    logic [5:0] last_day;

    always_comb begin
        sec_wrap  = (cur.sec  == 7'h59);
        min_wrap  = (cur.min  == 7'h59);
        hour_wrap = (cur.hour == 6'h23);
        last_day  = month_end(cur.mon, cur.leap);
        day_wrap  = (cur.mday == last_day);
        mon_wrap  = (cur.mon  == 5'h12);

        nxt     = cur;
        nxt.sec = sec_wrap ? 7'h00 : bcd_inc7(cur.sec);
        if (sec_wrap) begin
            nxt.min = min_wrap ? 7'h00 : bcd_inc7(cur.min);
            if (min_wrap) begin
                nxt.hour = hour_wrap ? 6'h00 : bcd_inc6(cur.hour);
                if (hour_wrap) begin
                    nxt.wday = (cur.wday == 3'd6) ? 3'd0 : cur.wday + 3'd1;
                    nxt.mday = day_wrap ? 6'h01 : bcd_inc6(cur.mday);
                    if (day_wrap) begin
                        nxt.mon = mon_wrap ? 5'h01 : bcd_inc5(cur.mon);
                        if (mon_wrap)
                            nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc8(cur.year);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/calclk_bcd.sv
module calclk_bcd
    import calclk_pkg::*;
#(
    parameter int PRESCALE_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    ld_state_t state_q, state_d;
    cal_time_t live_q, stage_q, next_time;
    logic      mode24_q;
    logic      tick, adv, trig_wr, loading;
    logic      unused_wr_bits;

    assign unused_wr_bits = ^wr_data[14:8];
    assign trig_wr        = wr_en && (wr_addr == A_TRIG) && wr_data[15];
    assign loading        = (state_q == ST_LOAD);
    assign adv            = (state_q == ST_RUN) && tick && mode24_q;

    calclk_prescaler #(.W(PRESCALE_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (loading),
        .tick  (tick)
    );

    calclk_advance u_adv (
        .cur (live_q),
        .nxt (next_time)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (trig_wr) state_d = ST_LOAD;
            ST_LOAD: state_d = trig_wr ? ST_LOAD : ST_RUN;
        endcase
    end

    // live time: load from staging or advance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            live_q <= CAL_RESET;
        else if (loading)
            live_q <= stage_q;
        else if (adv)
            live_q <= next_time;
    end

    // staging copy and control bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q  <= CAL_RESET;
            mode24_q <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_SEC:  stage_q.sec  <= wr_data[6:0];
                A_MIN:  stage_q.min  <= wr_data[6:0];
                A_HOUR: stage_q.hour <= wr_data[5:0];
                A_WDAY: stage_q.wday <= wr_data[2:0];
                A_MDAY: stage_q.mday <= wr_data[5:0];
                A_MON:  stage_q.mon  <= wr_data[4:0];
                A_YEAR: begin
                    stage_q.year <= wr_data[7:0];
                    stage_q.leap <= wr_data[15];
                end
                A_CTRL: mode24_q <= wr_data[0];
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        case (rd_addr)
            A_SEC:   rd_data = {9'd0, live_q.sec};
            A_MIN:   rd_data = {9'd0, live_q.min};
            A_HOUR:  rd_data = {10'd0, live_q.hour};
            A_WDAY:  rd_data = {13'd0, live_q.wday};
            A_MDAY:  rd_data = {10'd0, live_q.mday};
            A_MON:   rd_data = {11'd0, live_q.mon};
            A_YEAR:  rd_data = {live_q.leap, 7'd0, live_q.year};
            A_TRIG:  rd_data = {loading, 15'd0};
            A_CTRL:  rd_data = {15'd0, mode24_q};
            default: rd_data = '0;
        endcase
    end

    // R4
    load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loading |=> (live_q == $past(stage_q)));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !mode24_q) |=> $stable(live_q));

    // R5
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !tick) |=> $stable(live_q));

    // R7
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && live_q.sec == 7'h59) |=> (live_q.sec == 7'h00));

    // R10
    leap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> $stable(live_q.leap));

endmodule

// File: tb/calclk_bcd_tb.sv
module calclk_bcd_tb_top;
    localparam int CLK_PERIOD = 20;
    localparam int PW         = 2;
    localparam int CYC        = 1 << PW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    calclk_bcd #(.PRESCALE_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [15:0] bcd(input int v);
        return 16'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int days_in(input int m, input int lp);
        if (m == 2) return lp ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic chk_rd(input string req, input logic [3:0] a, input logic [15:0] exp);
        logic [15:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic stage(input int yr, input int lp, input int mo, input int dy,
                         input int wd, input int hh, input int mm, input int ss);
        wr(4'd0, bcd(ss));
        wr(4'd1, bcd(mm));
        wr(4'd2, bcd(hh));
        wr(4'd3, 16'(wd));
        wr(4'd4, bcd(dy));
        wr(4'd5, bcd(mo));
        wr(4'd6, {lp[0], 7'd0, bcd(yr)[7:0]});
    endtask

    // stage, trigger, and step to the negedge after the load edge
    task automatic load(input int yr, input int lp, input int mo, input int dy,
                        input int wd, input int hh, input int mm, input int ss);
        stage(yr, lp, mo, dy, wd, hh, mm, ss);
        wr(4'd7, 16'h8000);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_rd("R1 sec",  4'd0, 16'h0000);
        chk_rd("R1 min",  4'd1, 16'h0000);
        chk_rd("R1 hour", 4'd2, 16'h0000);
        chk_rd("R1 wday", 4'd3, 16'h0000);
        chk_rd("R1 mday", 4'd4, 16'h0001);
        chk_rd("R1 mon",  4'd5, 16'h0001);
        chk_rd("R1 year", 4'd6, 16'h0000);
        @(negedge clk);
        chk_rd("R1 trig", 4'd7, 16'h0000);
        chk_rd("R1 ctrl", 4'd8, 16'h0000);
        chk_rd("R2 unmapped", 4'd15, 16'h0000);

        // R6 / R3: mode off, load then ignored staging
        stage(12, 0, 3, 14, 2, 12, 34, 56);
        wr(4'd7, 16'h8000);
        chk_rd("R4 pending set", 4'd7, 16'h8000);
        @(negedge clk);
        chk_rd("R4 pending clear", 4'd7, 16'h0000);
        chk_rd("R4 loaded sec", 4'd0, bcd(56));
        chk_rd("R4 loaded hour", 4'd2, bcd(12));
        chk_rd("R2 year field", 4'd6, 16'h0012);
        repeat (3 * CYC) @(negedge clk);
        chk_rd("R6 held sec", 4'd0, bcd(56));
        stage(40, 1, 7, 9, 5, 1, 2, 11);
        wr(4'd7, 16'h7FFF);
        repeat (2) @(negedge clk);
        chk_rd("R3 sec unchanged", 4'd0, bcd(56));
        chk_rd("R3 min unchanged", 4'd1, bcd(34));
        chk_rd("R3 mon unchanged", 4'd5, bcd(3));
        wr(4'd8, 16'h0001);
        chk_rd("R2 ctrl readback", 4'd8, 16'h0001);
        wr(4'd7, 16'h8000);
        @(negedge clk);
        chk_rd("R3 staged sec applied", 4'd0, bcd(11));
        chk_rd("R3 staged year leap", 4'd6, 16'h8040);
        chk_rd("R3 staged wday", 4'd3, 16'd5);

        // R5 timing + R7/R11 sweep from 00:58:00
        load(0, 0, 1, 1, 0, 0, 58, 0);
        repeat (CYC - 1) @(negedge clk);
        chk_rd("R5 before first tick", 4'd0, 16'h0000);
        @(negedge clk);
        chk_rd("R5 first tick", 4'd0, 16'h0001);
        for (int n = 2; n <= 130; n++) begin
            int tot;
            repeat (CYC) @(negedge clk);
            tot = 58 * 60 + n;
            chk_rd("R7 R11 sec",  4'd0, bcd(tot % 60));
            chk_rd("R7 R11 min",  4'd1, bcd((tot / 60) % 60));
            chk_rd("R7 R11 hour", 4'd2, bcd(tot / 3600));
        end

        // R7 R8 R11: hour wrap carries to day, weekday 6 -> 0
        load(25, 0, 5, 19, 6, 23, 59, 59);
        repeat (CYC) @(negedge clk);
        chk_rd("R7 hour wrap", 4'd2, 16'h0000);
        chk_rd("R11 day 19->20", 4'd4, 16'h0020);
        chk_rd("R8 wday wrap", 4'd3, 16'd0);

        // R9 R10: month ends for both leap settings
        for (int lp = 0; lp < 2; lp++) begin
            for (int m = 1; m <= 12; m++) begin
                int last;
                int wd;
                last = days_in(m, lp);
                wd   = m % 7;
                load(25, lp, m, last - 1, wd, 23, 59, 59);
                repeat (CYC) @(negedge clk);
                chk_rd("R9 reach last day", 4'd4, bcd(last));
                chk_rd("R9 month kept", 4'd5, bcd(m));
                chk_rd("R8 wday step", 4'd3, 16'((wd == 6) ? 0 : wd + 1));
                load(25, lp, m, last, wd, 23, 59, 59);
                repeat (CYC) @(negedge clk);
                chk_rd("R9 day wrap", 4'd4, 16'h0001);
                chk_rd("R9 month step", 4'd5, bcd((m == 12) ? 1 : m + 1));
                chk_rd("R10 year", 4'd6, {lp[0], 7'd0, bcd((m == 12) ? 26 : 25)[7:0]});
            end
        end

        // R10 year 99 wraps, leap flag kept
        load(99, 1, 12, 31, 3, 23, 59, 59);
        repeat (CYC) @(negedge clk);
        chk_rd("R10 year wrap", 4'd6, 16'h8000);
        chk_rd("R10 month", 4'd5, 16'h0001);
        chk_rd("R10 day", 4'd4, 16'h0001);
        chk_rd("R10 sec", 4'd0, 16'h0000);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule